// File: doc/BRIEF.md
# DRAM Request Priority Arbiter

This block sits between the two caches, the write buffer and the DRAM controller. On every DRAM-clock edge it chooses one memory request to issue next: draining the write buffer, filling a data-cache line, filling an instruction-cache line, or nothing. The choice and its DRAM word address are both registered. A new request therefore appears one cycle after the inputs that caused it.

The priority order is fixed, and write-buffer pressure is treated in two ways. A busy memory controller always suppresses requests. A write buffer that has filled up is served before any cache miss. A data miss beats an instruction miss. A write buffer that holds entries but is not full is drained only when neither cache is waiting. For a line fill, the CPU byte address is reduced to a line index and padded with zero word bits, so that the DRAM address points at the first word of the line.

Top module: `dram_req_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `dram_cmd` = 0 (idle) and `dram_addr` = 0, whatever the other inputs are.
- R2: With `rst` low and `mem_busy` high at an edge, `dram_cmd` becomes 0 (idle) after that edge, even when misses or a full write buffer are pending.
- R3: With `rst` and `mem_busy` low and `wbuf_full` high, `dram_cmd` becomes 1 (write) after the edge, regardless of either miss flag.
- R4: With no reset, no busy and no full buffer, a high `dload_miss` makes `dram_cmd` 3 (data fill), whatever `ifetch_miss` and `wbuf_empty` are.
- R5: With no reset, no busy, no full buffer and no data miss, a high `ifetch_miss` makes `dram_cmd` 2 (instruction fill), even if the write buffer is not empty.
- R6: With none of the above, a low `wbuf_empty` makes `dram_cmd` 1 (write), and a high `wbuf_empty` makes it 0 (idle).
- R7: When the command becomes 1 (write), `dram_addr` equals the `wbuf_head_addr` that was sampled at the same edge.
- R8: When the command becomes 2, `dram_addr` equals `ifetch_addr[24:5]` in bits 22:3, with bits 2:0 set to zero.
- R9: When the command becomes 3, `dram_addr` equals `dload_addr[24:5]` in bits 22:3, with bits 2:0 set to zero.
- R10: When the command becomes 0, `dram_addr` is 0.
- R11: Both outputs change only on a rising clock edge. An input change between edges leaves them unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-side clock |
| rst | input | 1 | Synchronous reset, active high |
| ifetch_addr | input | 32 | Byte address of the instruction-cache miss |
| dload_addr | input | 32 | Byte address of the data-cache miss |
| ifetch_miss | input | 1 | Instruction cache requests a line fill |
| dload_miss | input | 1 | Data cache requests a line fill |
| wbuf_full | input | 1 | Write buffer has no free entry |
| wbuf_empty | input | 1 | Write buffer holds no entry |
| mem_busy | input | 1 | Memory controller cannot accept a request |
| wbuf_head_addr | input | 23 | DRAM word address of the oldest write-buffer entry |
| dram_cmd | output | 2 | Registered command: 0 idle, 1 write, 2 instruction fill, 3 data fill |
| dram_addr | output | 23 | Registered DRAM word address for the command |

## Verification
The bench builds the arbiter with its default parameters: a 32-bit CPU address, a 23-bit DRAM address and a 32-byte line. This places the line index in bits 24:5 with three zero pad bits. With these values, addresses that have every bit set, or bits only above bit 24, or bits only below bit 5, show directly whether the index is cut out in the right place. Random input patterns that include reset and busy cover every pairing of priority levels.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE    = 2'd0,
      CMD_WRITE   = 2'd1,
      CMD_RD_INST = 2'd2,
      CMD_RD_DATA = 2'd3
   } dram_cmd_e;
endpackage

// File: rtl/dram_arb_select.sv
// Fixed-priority choice of the next DRAM request (reset is applied in the register stage).
module dram_arb_select
   import dram_arb_pkg::*;
(
   input  logic      busy,
   input  logic      buf_full,
   input  logic      buf_empty,
   input  logic      data_miss,
   input  logic      inst_miss,
   output dram_cmd_e next_cmd
);
   always_comb begin
      if (busy)                next_cmd = CMD_IDLE;
      else if (buf_full)       next_cmd = CMD_WRITE;
      else if (data_miss)      next_cmd = CMD_RD_DATA;
      else if (inst_miss)      next_cmd = CMD_RD_INST;
      else if (!buf_empty)     next_cmd = CMD_WRITE;
      else                     next_cmd = CMD_IDLE;
   end
endmodule

// File: rtl/dram_arb_align.sv
// Turns a CPU byte address into the DRAM word address of the start of its line.
module dram_arb_align #(
   parameter int CPU_AW   = 32,
   parameter int DRAM_AW  = 23,
   parameter int LINE_LSB = 5,
   parameter int PAD_W    = 3
) (
   input  logic [CPU_AW-1:0]  byte_addr,
   output logic [DRAM_AW-1:0] line_addr
);
   localparam int FIELD_W = DRAM_AW - PAD_W;

   generate
      if (PAD_W == 0) begin : g_no_pad
         assign line_addr = byte_addr[LINE_LSB +: FIELD_W];
      end else begin : g_pad
         assign line_addr = {byte_addr[LINE_LSB +: FIELD_W], {PAD_W{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/dram_arb_outreg.sv
// Output register: picks the address that belongs to the chosen command and stores both.
module dram_arb_outreg
   import dram_arb_pkg::*;
#(
   parameter int DRAM_AW = 23
) (
   input  logic               clk,
   input  logic               rst,
   input  dram_cmd_e          next_cmd,
   input  logic [DRAM_AW-1:0] head_addr,
   input  logic [DRAM_AW-1:0] inst_line,
   input  logic [DRAM_AW-1:0] data_line,
   output dram_cmd_e          cmd_q,
   output logic [DRAM_AW-1:0] addr_q
);
   logic [DRAM_AW-1:0] addr_d;

   always_comb begin
      unique case (next_cmd)
         CMD_WRITE:   addr_d = head_addr;
         CMD_RD_INST: addr_d = inst_line;
         CMD_RD_DATA: addr_d = data_line;
         default:     addr_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cmd_q  <= CMD_IDLE;
         addr_q <= '0;
      end else begin
         cmd_q  <= next_cmd;
         addr_q <= addr_d;
      end
   end
endmodule

// File: rtl/dram_req_arbiter.sv
module dram_req_arbiter
   import dram_arb_pkg::*;
#(
   parameter int CPU_AW   = 32,
   parameter int DRAM_AW  = 23,
   parameter int LINE_LSB = 5,
   parameter int PAD_W    = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [CPU_AW-1:0]  ifetch_addr,
   input  logic [CPU_AW-1:0]  dload_addr,
   input  logic               ifetch_miss,
   input  logic               dload_miss,
   input  logic               wbuf_full,
   input  logic               wbuf_empty,
   input  logic               mem_busy,
   input  logic [DRAM_AW-1:0] wbuf_head_addr,
   output logic [1:0]         dram_cmd,
   output logic [DRAM_AW-1:0] dram_addr
);
   localparam int FIELD_W = DRAM_AW - PAD_W;
   localparam int FIELD_HI = LINE_LSB + FIELD_W - 1;

   generate
      if (FIELD_W < 1) begin : g_bad_pad
         $error("dram_req_arbiter: PAD_W must be smaller than DRAM_AW");
      end
      if (FIELD_HI >= CPU_AW) begin : g_bad_field
         $error("dram_req_arbiter: line index runs past the CPU address");
      end
   endgenerate

   dram_cmd_e          next_cmd;
   dram_cmd_e          cmd_q;
   logic [DRAM_AW-1:0] inst_line;
   logic [DRAM_AW-1:0] data_line;

   dram_arb_select u_select (
      .busy      (mem_busy),
      .buf_full  (wbuf_full),
      .buf_empty (wbuf_empty),
      .data_miss (dload_miss),
      .inst_miss (ifetch_miss),
      .next_cmd  (next_cmd)
   );

   dram_arb_align #(
      .CPU_AW(CPU_AW), .DRAM_AW(DRAM_AW), .LINE_LSB(LINE_LSB), .PAD_W(PAD_W)
   ) u_align_inst (
      .byte_addr (ifetch_addr),
      .line_addr (inst_line)
   );

   dram_arb_align #(
      .CPU_AW(CPU_AW), .DRAM_AW(DRAM_AW), .LINE_LSB(LINE_LSB), .PAD_W(PAD_W)
   ) u_align_data (
      .byte_addr (dload_addr),
      .line_addr (data_line)
   );

   dram_arb_outreg #(.DRAM_AW(DRAM_AW)) u_outreg (
      .clk       (clk),
      .rst       (rst),
      .next_cmd  (next_cmd),
      .head_addr (wbuf_head_addr),
      .inst_line (inst_line),
      .data_line (data_line),
      .cmd_q     (cmd_q),
      .addr_q    (dram_addr)
   );

   assign dram_cmd = cmd_q;
endmodule

// File: rtl/dram_req_arbiter_chk.sv
module dram_req_arbiter_chk #(
   parameter int CPU_AW   = 32,
   parameter int DRAM_AW  = 23,
   parameter int LINE_LSB = 5,
   parameter int PAD_W    = 3
) (
   input logic               clk,
   input logic               rst,
   input logic [CPU_AW-1:0]  ifetch_addr,
   input logic [CPU_AW-1:0]  dload_addr,
   input logic               ifetch_miss,
   input logic               dload_miss,
   input logic               wbuf_full,
   input logic               wbuf_empty,
   input logic               mem_busy,
   input logic [DRAM_AW-1:0] wbuf_head_addr,
   input logic [1:0]         dram_cmd,
   input logic [DRAM_AW-1:0] dram_addr
);
   logic [DRAM_AW-1:0] i_line_ref;
   logic [DRAM_AW-1:0] d_line_ref;
   assign i_line_ref = DRAM_AW'(ifetch_addr >> LINE_LSB) << PAD_W;
   assign d_line_ref = DRAM_AW'(dload_addr >> LINE_LSB) << PAD_W;

   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (dram_cmd == 2'd0 && dram_addr == '0));

   p_busy_idle_r2: assert property (@(posedge clk) disable iff (rst)
      mem_busy |=> (dram_cmd == 2'd0));

   // R3 with R7
   p_full_write_r3: assert property (@(posedge clk) disable iff (rst)
      (!mem_busy && wbuf_full) |=> (dram_cmd == 2'd1 && dram_addr == $past(wbuf_head_addr)));

   // R4 with R9
   p_data_fill_r4: assert property (@(posedge clk) disable iff (rst)
      (!mem_busy && !wbuf_full && dload_miss)
      |=> (dram_cmd == 2'd3 && dram_addr == $past(d_line_ref)));

   // R5 with R8
   p_inst_fill_r5: assert property (@(posedge clk) disable iff (rst)
      (!mem_busy && !wbuf_full && !dload_miss && ifetch_miss)
      |=> (dram_cmd == 2'd2 && dram_addr == $past(i_line_ref)));

   p_drain_r6: assert property (@(posedge clk) disable iff (rst)
      (!mem_busy && !wbuf_full && !dload_miss && !ifetch_miss && !wbuf_empty)
      |=> (dram_cmd == 2'd1 && dram_addr == $past(wbuf_head_addr)));

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
      (!mem_busy && !wbuf_full && !dload_miss && !ifetch_miss && wbuf_empty)
      |=> (dram_cmd == 2'd0 && dram_addr == '0));
endmodule

bind dram_req_arbiter dram_req_arbiter_chk #(
   .CPU_AW(CPU_AW), .DRAM_AW(DRAM_AW), .LINE_LSB(LINE_LSB), .PAD_W(PAD_W)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .ifetch_addr    (ifetch_addr),
   .dload_addr     (dload_addr),
   .ifetch_miss    (ifetch_miss),
   .dload_miss     (dload_miss),
   .wbuf_full      (wbuf_full),
   .wbuf_empty     (wbuf_empty),
   .mem_busy       (mem_busy),
   .wbuf_head_addr (wbuf_head_addr),
   .dram_cmd       (dram_cmd),
   .dram_addr      (dram_addr)
);

// File: tb/dram_req_arbiter_bench.sv
module dram_req_arbiter_bench;
   localparam int CPU_AW  = 32;
   localparam int DRAM_AW = 23;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic               rst;
   logic [CPU_AW-1:0]  ifetch_addr, dload_addr;
   logic               ifetch_miss, dload_miss, wbuf_full, wbuf_empty, mem_busy;
   logic [DRAM_AW-1:0] wbuf_head_addr;
   logic [1:0]         dram_cmd;
   logic [DRAM_AW-1:0] dram_addr;

   int checks = 0;
   int errors = 0;

   logic [1:0]         exp_cmd;
   logic [DRAM_AW-1:0] exp_addr;
   string              cmd_tag, addr_tag;

   dram_req_arbiter u_dram_req_arbiter (
      .clk(clk), .rst(rst), .ifetch_addr(ifetch_addr), .dload_addr(dload_addr),
      .ifetch_miss(ifetch_miss), .dload_miss(dload_miss), .wbuf_full(wbuf_full),
      .wbuf_empty(wbuf_empty), .mem_busy(mem_busy), .wbuf_head_addr(wbuf_head_addr),
      .dram_cmd(dram_cmd), .dram_addr(dram_addr)
   );

   // first word of the 32-byte line, as a 23-bit DRAM word address
   function automatic logic [DRAM_AW-1:0] line_word(input logic [31:0] a);
      longint unsigned idx;
      idx = (longint'(a) / 32) % (longint'(1) << 20);
      return DRAM_AW'(idx * 8);
   endfunction

   // reference model for the current input values
   task automatic predict();
      if (rst) begin
         exp_cmd = 0; exp_addr = 0; cmd_tag = "R1"; addr_tag = "R1";
      end else if (mem_busy) begin
         exp_cmd = 0; exp_addr = 0; cmd_tag = "R2"; addr_tag = "R10";
      end else if (wbuf_full) begin
         exp_cmd = 1; exp_addr = wbuf_head_addr; cmd_tag = "R3"; addr_tag = "R7";
      end else if (dload_miss) begin
         exp_cmd = 3; exp_addr = line_word(dload_addr); cmd_tag = "R4"; addr_tag = "R9";
      end else if (ifetch_miss) begin
         exp_cmd = 2; exp_addr = line_word(ifetch_addr); cmd_tag = "R5"; addr_tag = "R8";
      end else if (!wbuf_empty) begin
         exp_cmd = 1; exp_addr = wbuf_head_addr; cmd_tag = "R6"; addr_tag = "R7";
      end else begin
         exp_cmd = 0; exp_addr = 0; cmd_tag = "R6"; addr_tag = "R10";
      end
   endtask

   task automatic compare(input string ctag, input string atag);
      checks++;
      if (dram_cmd !== exp_cmd) begin
         errors++;
         $display("FAIL %s cmd: actual %0d expected %0d", ctag, dram_cmd, exp_cmd);
      end
      checks++;
      if (dram_addr !== exp_addr) begin
         errors++;
         $display("FAIL %s addr: actual %06h expected %06h", atag, dram_addr, exp_addr);
      end
   endtask

   task automatic set_in(input logic r, input logic b, input logic f, input logic e,
                         input logic dm, input logic im, input logic [31:0] ia,
                         input logic [31:0] da, input logic [22:0] ha);
      rst = r; mem_busy = b; wbuf_full = f; wbuf_empty = e;
      dload_miss = dm; ifetch_miss = im;
      ifetch_addr = ia; dload_addr = da; wbuf_head_addr = ha;
   endtask

   // called at a falling edge: result sampled 2 ns after the next rising edge
   task automatic run_cycle();
      predict();
      @(posedge clk);
      #2;
      compare(cmd_tag, addr_tag);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R11 watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      set_in(1, 0, 1, 0, 1, 1, 32'h1234_5678, 32'h8765_4321, 23'h5A5A5);
      @(negedge clk);
      // R1: reset overrides a full buffer and both misses
      run_cycle();
      run_cycle();
      // R6 / R10: nothing pending
      set_in(0, 0, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 23'h7FFFFF); run_cycle();
      // R2: busy beats everything
      set_in(0, 1, 1, 0, 1, 1, 32'h0000_0040, 32'h0000_0080, 23'h00_0011); run_cycle();
      // R3 / R7: full buffer beats both misses
      set_in(0, 0, 1, 0, 1, 1, 32'h0000_0040, 32'h0000_0080, 23'h3C_1234); run_cycle();
      // R4 / R9: data miss, all address bits set
      set_in(0, 0, 0, 0, 1, 1, 32'h0000_0020, 32'hFFFF_FFFF, 23'h00_0001); run_cycle();
      // R9: only bits above 24 set -> zero line
      set_in(0, 0, 0, 1, 1, 0, 32'h0, 32'hFE00_0000, 23'h0); run_cycle();
      // R5 / R8: instruction miss beats non-empty buffer, low offset bits dropped
      set_in(0, 0, 0, 0, 0, 1, 32'h0000_001F, 32'hFFFF_FFFF, 23'h12_3456); run_cycle();
      set_in(0, 0, 0, 0, 0, 1, 32'h01AB_CDE0, 32'h0, 23'h12_3456); run_cycle();
      // R6 / R7: drain when nothing else waits
      set_in(0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 23'h6D_B6DB); run_cycle();
      // R11: outputs hold until the next edge
      set_in(0, 0, 1, 0, 0, 0, 32'h0, 32'h0, 23'h01_0203); run_cycle();
      set_in(0, 0, 0, 0, 1, 0, 32'h0, 32'h00AB_CD00, 23'h0);
      #3;
      compare("R11", "R11");
      #2;
      run_cycle();
      // reset in mid-run then recovery
      set_in(1, 0, 0, 0, 0, 1, 32'h0000_1000, 32'h0, 23'h0); run_cycle();
      set_in(0, 0, 0, 0, 0, 1, 32'h0000_1000, 32'h0, 23'h0); run_cycle();
      // random patterns covering all priority pairings
      for (int n = 0; n < 600; n++) begin
         set_in(($urandom % 40) == 0, ($urandom % 6) == 0, ($urandom % 4) == 0,
                ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0,
                $urandom, $urandom, DRAM_AW'($urandom));
         run_cycle();
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule